// File: doc/BRIEF.md
# Pipeline Interlock Control Unit

This unit decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back) may move on. It receives the decode-stage instruction's operand fields, its destination, and a few attribute bits. It keeps its own record of what entered the execute slot one cycle earlier. When the instruction cannot proceed safely, it freezes the fetch and decode registers and places a no-op bubble in execute. Instructions already in execute, memory access and write-back keep moving.

Three causes of a stall are detected. The first is a load-use dependency: a load's data arrives only during memory access, so the forwarding network cannot supply it to the very next instruction. The second is a stack-pointer selection dependency: register 15 maps to one of two stack pointers, chosen by the stack flag, so an instruction that touches register 15, or that belongs to the TYPE-A format class, must not read it right after an instruction that rewrites the flag. The third is an external resource-busy condition. The causes are combined with OR, and a single stall cycle both holds the front end and inserts a bubble.

Top module: `pipe_interlock`

## Requirements
- R1: While reset is low and immediately after it is released, the execute record is empty, so no instruction in decode is stalled unless the resource-busy input is high.
- R2: When the execute record holds a valid load with its register write enabled, and a source field of a valid decode instruction is marked used and equals that load's destination, hold_fetch and bubble_ex are 1 in that cycle.
- R3: A non-load instruction in execute, a load whose write enable is 0, or a source field whose used bit is 0 never causes a data stall, because such results are forwarded.
- R4: A load-use stall lasts exactly one cycle. In the following cycle the dependent instruction, still in decode, proceeds with hold_fetch at 0.
- R5: When the execute record holds a valid instruction that writes the stack flag, and the decode instruction references register 15, a stall is raised. A reference means id_sp_ref is 1 or a used source field equals 15 (binary 1111).
- R6: When the execute record holds a valid stack-flag writer and the decode instruction has id_type_a at 1, a stall is raised even if register 15 is not named.
- R7: A stack-flag stall lasts exactly one cycle.
- R8: While res_busy is 1 and the decode instruction is valid, a stall is raised every cycle. It is released in the first cycle res_busy is 0, provided no other cause applies.
- R9: In a stall cycle hold_fetch and bubble_ex are both 1, and the execute record takes a bubble at the next edge. Without a stall, a valid decode instruction enters the execute record at the next edge.
- R10: When id_valid is 0, hold_fetch and bubble_ex are 0 whatever the other inputs are.
- R11: Stall causes combine by OR. A load-use hazard and a stack-flag hazard raised by the same producer still give one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src | input | NUM_SRC x REG_AW | Source register numbers of the decode instruction |
| id_src_used | input | NUM_SRC | Per-source flag: the field is actually read |
| id_sp_ref | input | 1 | Decode instruction references register 15 implicitly |
| id_type_a | input | 1 | Decode instruction is of the TYPE-A format class |
| id_dst | input | REG_AW | Destination register of the decode instruction |
| id_dst_we | input | 1 | Decode instruction writes its destination |
| id_is_load | input | 1 | Decode instruction is a memory load |
| id_wr_sflag | input | 1 | Decode instruction rewrites the stack flag |
| res_busy | input | 1 | A shared hardware resource is still occupied |
| hold_fetch | output | 1 | Freeze the fetch and decode registers |
| bubble_ex | output | 1 | Insert a no-op into execute |

## Verification
The bench sweeps every pairing of load destination and consumer source on both source slots, with and without the used bit and with non-load producers. A comparator on the wrong width or a missing used-bit gate would stall on a forwarded value or miss a genuine dependency. It also checks the cycle after each stall. A design that failed to bubble the execute record would stall forever, and one that dropped the producer too early would let the consumer read stale data. Every combination of flag-writer, implicit register-15 reference, explicit source 15 (used and unused) and TYPE-A class is crossed, so that a design ignoring the format class, or treating an unused field naming 15 as a reference, is exposed. Busy windows of several lengths, an invalid decode slot, and overlapping causes catch stalls that end one cycle early or late, or that fire on an empty slot.

// File: rtl/pi_pkg.sv
package pi_pkg;

  localparam int unsigned PI_REG_AW  = 4;
  localparam int unsigned PI_NUM_SRC = 2;

  // Attributes carried by the instruction occupying the execute slot.
  typedef struct packed {
    logic valid;
    logic wr_en;
    logic is_load;
    logic wr_sflag;
  } slot_attr_t;

  localparam slot_attr_t SLOT_EMPTY = '{valid: 1'b0, wr_en: 1'b0,
                                        is_load: 1'b0, wr_sflag: 1'b0};

endpackage

// File: rtl/pi_ex_slot.sv
module pi_ex_slot
  import pi_pkg::*;
#(
  parameter int unsigned REG_AW = PI_REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  slot_attr_t        id_attr,
  input  logic [REG_AW-1:0] id_dst,
  output slot_attr_t        ex_attr,
  output logic [REG_AW-1:0] ex_dst
);

  slot_attr_t        attr_d;
  slot_attr_t        attr_q;
  logic              dst_en;
  logic [REG_AW-1:0] dst_q;

  // Next state: a stall turns the slot into a bubble; otherwise it takes decode.
  always_comb begin
    attr_d = SLOT_EMPTY;
    dst_en = 1'b0;
    if (!stall && id_attr.valid) begin
      attr_d = id_attr;
      dst_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= SLOT_EMPTY;
    end else begin
      attr_q <= attr_d;
    end
  end

  // Destination only loads when a real instruction enters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (dst_en) begin
      dst_q <= id_dst;
    end
  end

  assign ex_attr = attr_q;
  assign ex_dst  = dst_q;

endmodule

// File: rtl/pi_load_use.sv
module pi_load_use
  import pi_pkg::*;
#(
  parameter int unsigned REG_AW  = PI_REG_AW,
  parameter int unsigned NUM_SRC = PI_NUM_SRC
) (
  input  logic                           id_valid,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
  input  logic [NUM_SRC-1:0]             id_src_used,
  input  logic                           ex_load_live,
  input  logic [REG_AW-1:0]              ex_dst,
  output logic                           hit
);

  logic [NUM_SRC-1:0] src_match;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_match[g] = id_src_used[g] && (id_src[g] == ex_dst);
  end

  assign hit = id_valid && ex_load_live && (|src_match);

endmodule

// File: rtl/pi_sp_guard.sv
module pi_sp_guard
  import pi_pkg::*;
#(
  parameter int unsigned REG_AW   = PI_REG_AW,
  parameter int unsigned NUM_SRC  = PI_NUM_SRC,
  parameter int unsigned SP_INDEX = (1 << PI_REG_AW) - 1
) (
  input  logic                           id_valid,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
  input  logic [NUM_SRC-1:0]             id_src_used,
  input  logic                           id_sp_ref,
  input  logic                           id_type_a,
  input  logic                           ex_sflag_live,
  output logic                           hit
);

  localparam logic [REG_AW-1:0] SP_CODE = REG_AW'(SP_INDEX);

  logic [NUM_SRC-1:0] names_sp;
  logic               sensitive;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign names_sp[g] = id_src_used[g] && (id_src[g] == SP_CODE);
  end

  assign sensitive = id_sp_ref || id_type_a || (|names_sp);
  assign hit       = id_valid && ex_sflag_live && sensitive;

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pi_pkg::*;
#(
  parameter int unsigned REG_AW   = PI_REG_AW,
  parameter int unsigned NUM_SRC  = PI_NUM_SRC,
  parameter int unsigned SP_INDEX = (1 << REG_AW) - 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           id_valid,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
  input  logic [NUM_SRC-1:0]             id_src_used,
  input  logic                           id_sp_ref,
  input  logic                           id_type_a,
  input  logic [REG_AW-1:0]              id_dst,
  input  logic                           id_dst_we,
  input  logic                           id_is_load,
  input  logic                           id_wr_sflag,
  input  logic                           res_busy,
  output logic                           hold_fetch,
  output logic                           bubble_ex
);

  slot_attr_t        id_attr;
  slot_attr_t        ex_attr;
  logic [REG_AW-1:0] ex_dst;
  logic              ex_load_live;
  logic              ex_sflag_live;
  logic              lu_hit;
  logic              sp_hit;
  logic              busy_hit;
  logic              stall;

  always_comb begin
    id_attr.valid    = id_valid;
    id_attr.wr_en    = id_dst_we;
    id_attr.is_load  = id_is_load;
    id_attr.wr_sflag = id_wr_sflag;
  end

  assign ex_load_live  = ex_attr.valid && ex_attr.is_load && ex_attr.wr_en;
  assign ex_sflag_live = ex_attr.valid && ex_attr.wr_sflag;

  pi_ex_slot #(.REG_AW(REG_AW)) u_ex_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .id_attr (id_attr),
    .id_dst  (id_dst),
    .ex_attr (ex_attr),
    .ex_dst  (ex_dst)
  );

  pi_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_load_use (
    .id_valid     (id_valid),
    .id_src       (id_src),
    .id_src_used  (id_src_used),
    .ex_load_live (ex_load_live),
    .ex_dst       (ex_dst),
    .hit          (lu_hit)
  );

  pi_sp_guard #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .SP_INDEX(SP_INDEX)) u_sp_guard (
    .id_valid      (id_valid),
    .id_src        (id_src),
    .id_src_used   (id_src_used),
    .id_sp_ref     (id_sp_ref),
    .id_type_a     (id_type_a),
    .ex_sflag_live (ex_sflag_live),
    .hit           (sp_hit)
  );

  assign busy_hit   = id_valid && res_busy;
  assign stall      = lu_hit || sp_hit || busy_hit;
  assign hold_fetch = stall;
  assign bubble_ex  = stall;

endmodule

// File: rtl/pi_checker.sv
module pi_checker #(
  parameter int unsigned REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic              res_busy,
  input logic              hold_fetch,
  input logic              bubble_ex,
  input logic              lu_hit,
  input logic              sp_hit,
  input logic              ex_valid,
  input logic [REG_AW-1:0] ex_dst,
  input logic [REG_AW-1:0] id_dst
);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!hold_fetch && !bubble_ex));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && res_busy) |-> (hold_fetch && bubble_ex));

  assert_load_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hit |=> !lu_hit);

  assert_sp_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_hit |=> !sp_hit);

  assert_bubble_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |=> !ex_valid);

  assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !hold_fetch) |=> (ex_valid && ex_dst == $past(id_dst)));

endmodule

bind pipe_interlock pi_checker #(.REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid   (id_valid),
  .res_busy   (res_busy),
  .hold_fetch (hold_fetch),
  .bubble_ex  (bubble_ex),
  .lu_hit     (lu_hit),
  .sp_hit     (sp_hit),
  .ex_valid   (ex_attr.valid),
  .ex_dst     (ex_dst),
  .id_dst     (id_dst)
);

// File: tb/pipe_interlock_test.sv
module pipe_interlock_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NS = 2;

  logic                   clk;
  logic                   rst_n;
  logic                   id_valid;
  logic [NS-1:0][AW-1:0]  id_src;
  logic [NS-1:0]          id_src_used;
  logic                   id_sp_ref;
  logic                   id_type_a;
  logic [AW-1:0]          id_dst;
  logic                   id_dst_we;
  logic                   id_is_load;
  logic                   id_wr_sflag;
  logic                   res_busy;
  logic                   hold_fetch;
  logic                   bubble_ex;

  int checks;
  int errors;
  bit done;

  // Reference occupancy of the execute slot.
  bit            r_valid;
  bit            r_load;
  bit            r_we;
  bit            r_ws;
  logic [AW-1:0] r_dst;

  pipe_interlock uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src(id_src),
    .id_src_used(id_src_used), .id_sp_ref(id_sp_ref), .id_type_a(id_type_a),
    .id_dst(id_dst), .id_dst_we(id_dst_we), .id_is_load(id_is_load),
    .id_wr_sflag(id_wr_sflag), .res_busy(res_busy),
    .hold_fetch(hold_fetch), .bubble_ex(bubble_ex)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_stall();
    bit lu;
    bit sp;
    lu = 1'b0;
    sp = id_sp_ref || id_type_a;
    for (int i = 0; i < NS; i++) begin
      if (id_src_used[i] && id_src[i] == r_dst) lu = 1'b1;
      if (id_src_used[i] && id_src[i] == 4'd15) sp = 1'b1;
    end
    lu = lu && r_valid && r_load && r_we;
    sp = sp && r_valid && r_ws;
    return id_valid && (lu || sp || res_busy);
  endfunction

  task automatic check(input string req);
    bit e;
    e = exp_stall();
    #1;
    checks++;
    if (hold_fetch !== e || bubble_ex !== e) begin
      errors++;
      $display("FAIL %s: hold_fetch=%0b bubble_ex=%0b expected %0b", req,
               hold_fetch, bubble_ex, e);
    end
  endtask

  task automatic step();
    bit e;
    e = exp_stall();
    @(posedge clk);
    if (!e && id_valid) begin
      r_valid = 1'b1; r_load = id_is_load; r_we = id_dst_we;
      r_ws = id_wr_sflag; r_dst = id_dst;
    end else begin
      r_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    id_valid = 0; id_src = '0; id_src_used = '0; id_sp_ref = 0; id_type_a = 0;
    id_dst = '0; id_dst_we = 0; id_is_load = 0; id_wr_sflag = 0; res_busy = 0;
  endtask

  task automatic producer(input logic [AW-1:0] d, input bit ld, input bit we, input bit ws);
    idle();
    id_valid = 1; id_dst = d; id_is_load = ld; id_dst_we = we; id_wr_sflag = ws;
  endtask

  task automatic consumer(input logic [AW-1:0] a, input bit ua,
                          input logic [AW-1:0] b, input bit ub,
                          input bit spr, input bit ta);
    idle();
    id_valid = 1; id_src[0] = a; id_src[1] = b; id_src_used = {ub, ua};
    id_sp_ref = spr; id_type_a = ta; id_dst = 4'd1; id_dst_we = 1;
  endtask

  initial begin
    done = 0; checks = 0; errors = 0;
    r_valid = 0; r_load = 0; r_we = 0; r_ws = 0; r_dst = '0;
    idle();
    rst_n = 0;
    // R1: reset with a consumer waiting in decode
    consumer(4'd0, 1, 4'd0, 1, 1, 1);
    check("R1");
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1;
    check("R1");
    step();
    idle(); step();

    // R2 / R3 / R4: load-use sweep over destination, source, slot and mode
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        for (int m = 0; m < 8; m++) begin
          for (int s = 0; s < 2; s++) begin
            producer(p[AW-1:0], m[0], !m[2], 1'b0);
            step();
            if (s == 0) consumer(q[AW-1:0], m[1], q[AW-1:0], 1'b0, 0, 0);
            else        consumer(q[AW-1:0], 1'b0, q[AW-1:0], m[1], 0, 0);
            if (m[0] && m[1] && !m[2] && p == q) check("R2");
            else check("R3");
            step();
            check("R4");
            step();
            idle(); step();
          end
        end
      end
    end

    // R5 / R6 / R7: stack-flag interlock over all reference forms
    for (int ws = 0; ws < 2; ws++) begin
      for (int spr = 0; spr < 2; spr++) begin
        for (int ta = 0; ta < 2; ta++) begin
          for (int f = 0; f < 3; f++) begin
            producer(4'd3, 1'b0, 1'b1, ws[0]);
            step();
            consumer((f != 0) ? 4'd15 : 4'd2, f == 1, 4'd4, 1'b1, spr[0], ta[0]);
            if (ta[0] && !spr[0] && f != 1) check("R6");
            else check("R5");
            step();
            check("R7");
            step();
            idle(); step();
          end
        end
      end
    end

    // R11: one producer raising both causes
    producer(4'd15, 1'b1, 1'b1, 1'b1);
    step();
    consumer(4'd15, 1, 4'd0, 0, 0, 1);
    check("R11");
    step();
    check("R11");
    step();
    idle(); step();

    // R8: busy windows of several lengths, also overlapping a load-use
    for (int n = 1; n <= 5; n++) begin
      producer(4'd6, 1'b1, 1'b1, 1'b0);
      step();
      consumer(4'd6, 1, 4'd7, 1, 0, 0);
      res_busy = 1;
      for (int k = 0; k < n; k++) begin
        check("R8");
        step();
      end
      res_busy = 0;
      check("R8");
      step();
      idle(); step();
    end

    // R10: invalid decode slot with every cause present
    producer(4'd5, 1'b1, 1'b1, 1'b1);
    step();
    consumer(4'd5, 1, 4'd15, 1, 1, 1);
    id_valid = 0;
    res_busy = 1;
    check("R10");
    step();
    idle(); step();

    // R9: stalled instruction advances after bubble, then becomes a producer
    producer(4'd8, 1'b1, 1'b1, 1'b0);
    step();
    consumer(4'd8, 1, 4'd0, 0, 0, 0);
    id_is_load = 1; id_dst = 4'd9;
    check("R9");
    step();
    check("R9");
    step();
    consumer(4'd9, 1, 4'd0, 0, 0, 0);
    check("R9");
    step();
    idle(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule